// File: doc/BRIEF.md
# Dual-Channel Drive Interrupt Gate

This block sits on a byte-wide register bus of a two-channel disk interface card and merges the interrupt lines of two drive channels into one host interrupt. Each channel's raw drive interrupt passes through a two-flop synchronizer and appears as bit 0 of that channel's status byte, whether or not the channel is armed. A channel forwards its synchronized interrupt to the shared host line only while its gate is armed. The gate is a two-state machine per channel driven purely by access side effects on that channel's gate address: a bus write of any data value arms it, and a bus read disarms it.

The same decoder also serves a read-only card identity nibble, spread as bit 0 of four bytes, and a routing register whose bit 0 steers the DMA path to the second channel and whose bit 5 opens the extended register window. Read data is combinational during the strobe cycle; access side effects take place at the clock edge that ends the strobe cycle.

Each channel gate has two states, `GATE_MASKED` (reset state, interrupt held off the host line) and `GATE_ARMED` (interrupt forwarded). Transition ARM (`GATE_MASKED` or `GATE_ARMED` to `GATE_ARMED`) happens on a write to the channel's gate address; transition DISARM (any state to `GATE_MASKED`) happens on a read of that address with no write in the same cycle. If a read and a write hit the gate address together, ARM wins. Any other cycle keeps the state.

Top module: `ide_irq_gate`

## Requirements
- R1: After reset both channel gates are in `GATE_MASKED`, `host_irq` is 0, and `dma_ch2_sel` and `xreg_en` are 0.
- R2: A write of any data value to a channel's gate address (channel 1 at 0x2200, channel 2 at 0x3200) arms that channel's gate from the next clock edge on.
- R3: A read of a channel's gate address returns 0x00 and disarms that channel's gate at the edge ending the read cycle.
- R4: A read of a channel's status address (channel 1 at 0x2290, channel 2 at 0x3290) returns the raw drive interrupt of that channel, delayed by two clock edges, in bit 0 and zeros in bits 7:1, regardless of the gate state.
- R5: `host_irq` is high exactly when, for at least one channel, the gate is armed and the synchronized status bit is 1; it follows the status level, with no latching of its own.
- R6: Reads of 0x2280, 0x2284, 0x2288 and 0x228C return bits 0, 1, 2 and 3 of the card identity value (default 3, so 1, 1, 0, 0) in bit 0, with bits 7:1 zero.
- R7: A write to address 0x0000 stores data bit 0 into `dma_ch2_sel` (1 selects channel 2) and data bit 5 into `xreg_en`; a read of 0x0000 returns those two bits in positions 0 and 5 and zeros elsewhere; writing 0x00 clears both.
- R8: A read of any other address returns 0x00 and leaves both gate states and the routing register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, else 0 |
| drv_irq | input | 2 | Raw drive interrupts, bit 0 for channel 1 |
| host_irq | output | 1 | Merged, gated host interrupt |
| dma_ch2_sel | output | 1 | DMA path routed to channel 2 when 1 |
| xreg_en | output | 1 | Extended register window enabled when 1 |

## Verification
A gate stuck in the wrong state shows up on `host_irq` in the first cycle after the access that should have moved it, as long as that channel's drive interrupt is asserted, so the bench holds an interrupt high while arming and disarming. A wrong synchronizer depth or a lost status bit shows at the status byte read three cycles after the raw line changes. A decoder that hits the wrong address shows as nonzero read data on an unmapped read or as a host interrupt that drops after an unrelated read.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    typedef enum logic {
        GATE_MASKED = 1'b0,
        GATE_ARMED  = 1'b1
    } gate_state_e;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 8;

endpackage

// File: rtl/ide_irq_sync.sv
module ide_irq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_sync) |-> $past(d_async, 2)); // R4

endmodule

// File: rtl/ide_irq_chan.sv
module ide_irq_chan
    import ide_irq_pkg::*;
#(
    parameter int               AW       = BUS_AW,
    parameter logic [AW-1:0]    GATE_ADR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          stat_in,
    output logic          armed,
    output logic          irq_out
);

    gate_state_e state_q, state_d;
    logic        hit;

    assign hit = (bus_addr == GATE_ADR);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_MASKED: if (hit && bus_wr)      state_d = GATE_ARMED;
            GATE_ARMED:  if (hit && bus_wr)      state_d = GATE_ARMED;
                         else if (hit && bus_rd) state_d = GATE_MASKED;
            default:     state_d = GATE_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        armed   = (state_q == GATE_ARMED);
        irq_out = armed && stat_in;
    end

    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr) |=> armed); // R2
    AST_DISARM_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_rd && !bus_wr) |=> !armed); // R3
    AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && (bus_rd || bus_wr)) |=> $stable(armed)); // R8

endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
    import ide_irq_pkg::*;
#(
    parameter int             N_CH      = 2,
    parameter logic [15:0]    GATE_BASE = 16'h2200,
    parameter logic [15:0]    CH_STRIDE = 16'h1000,
    parameter logic [15:0]    STAT_OFS  = 16'h0090,
    parameter logic [15:0]    ID_BASE   = 16'h2280,
    parameter int             ID_STEP   = 4,
    parameter int             ID_BITS   = 4,
    parameter logic [3:0]     CARD_ID   = 4'd3,
    parameter logic [15:0]    ROUTE_ADR = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_CH-1:0]   drv_irq,
    output logic              host_irq,
    output logic              dma_ch2_sel,
    output logic              xreg_en
);

    localparam int SEL_BIT = 0;
    localparam int XREG_BIT = 5;

    logic [N_CH-1:0] stat_s;
    logic [N_CH-1:0] armed_s;
    logic [N_CH-1:0] irq_s;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam logic [15:0] GADR = GATE_BASE + 16'(c) * CH_STRIDE;

        ide_irq_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (drv_irq[c]),
            .q_sync  (stat_s[c])
        );

        ide_irq_chan #(.AW(BUS_AW), .GATE_ADR(GADR)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_addr (bus_addr),
            .bus_rd   (bus_rd),
            .bus_wr   (bus_wr),
            .stat_in  (stat_s[c]),
            .armed    (armed_s[c]),
            .irq_out  (irq_s[c])
        );
    end

    assign host_irq = |irq_s;

    // routing register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_ch2_sel <= 1'b0;
            xreg_en     <= 1'b0;
        end else if (bus_wr && bus_addr == ROUTE_ADR) begin
            dma_ch2_sel <= bus_wdata[SEL_BIT];
            xreg_en     <= bus_wdata[XREG_BIT];
        end
    end

    // read decode
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ROUTE_ADR) begin
                bus_rdata[SEL_BIT]  = dma_ch2_sel;
                bus_rdata[XREG_BIT] = xreg_en;
            end
            for (int c = 0; c < N_CH; c++) begin
                if (bus_addr == GATE_BASE + 16'(c) * CH_STRIDE + STAT_OFS)
                    bus_rdata[0] = stat_s[c];
            end
            for (int k = 0; k < ID_BITS; k++) begin
                if (bus_addr == ID_BASE + 16'(k * ID_STEP))
                    bus_rdata[0] = CARD_ID[k];
            end
        end
    end

    AST_ROUTE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ROUTE_ADR) |=>
        (dma_ch2_sel == $past(bus_wdata[SEL_BIT]) && xreg_en == $past(bus_wdata[XREG_BIT]))); // R7
    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ROUTE_ADR) |=> ($stable(dma_ch2_sel) && $stable(xreg_en))); // R8
    AST_HOST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_s == '0) |-> !host_irq); // R5
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00)); // R8

endmodule

// File: tb/ide_irq_gate_bench.sv
module ide_irq_gate_bench;

    typedef struct {
        logic [7:0]  exp;
        logic [15:0] adr;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  drv_irq = '0;
    logic        host_irq, dma_ch2_sel, xreg_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    rd_item_t sb_q[$];

    always #10 clk = ~clk;

    ide_irq_gate u_ide_irq_gate (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drv_irq(drv_irq), .host_irq(host_irq), .dma_ch2_sel(dma_ch2_sel),
        .xreg_en(xreg_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = 16'h7ffe;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.adr = a; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); #1;
        bus_rd = 1'b0; bus_addr = 16'h7ffe;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    // monitor: compares read data against the scoreboard mid-cycle
    initial begin
        forever begin
            @(negedge clk); #5;
            if (bus_rd) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "unexpected read", 0, 0);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    check(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bus_addr = 16'h7ffe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check(host_irq == 1'b0, "R1 host_irq after reset", host_irq, 0);
        check(dma_ch2_sel == 1'b0 && xreg_en == 1'b0, "R1 route after reset",
              {dma_ch2_sel, xreg_en}, 0);
        do_read(16'h2290, 8'h00, "R4 ch1 status idle");

        do_read(16'h2280, 8'h01, "R6 id bit0");
        do_read(16'h2284, 8'h01, "R6 id bit1");
        do_read(16'h2288, 8'h00, "R6 id bit2");
        do_read(16'h228C, 8'h00, "R6 id bit3");

        drv_irq = 2'b01;
        idle(3);
        check(host_irq == 1'b0, "R1 R5 masked ch1 stays off host", host_irq, 0);
        do_read(16'h2290, 8'h01, "R4 ch1 status while masked");

        do_write(16'h2200, 8'hA5);
        idle(0);
        check(host_irq == 1'b1, "R2 R5 ch1 armed forwards", host_irq, 1);
        do_read(16'h3290, 8'h00, "R4 ch2 status idle");
        do_read(16'h1234, 8'h00, "R8 unmapped read");
        do_read(16'h2204, 8'h00, "R8 near-miss read");
        idle(0);
        check(host_irq == 1'b1, "R8 unmapped reads keep gate", host_irq, 1);

        do_read(16'h2200, 8'h00, "R3 gate read data");
        idle(0);
        check(host_irq == 1'b0, "R3 read disarms ch1", host_irq, 0);

        drv_irq = 2'b10;
        idle(3);
        do_write(16'h3200, 8'h00);
        idle(0);
        check(host_irq == 1'b1, "R2 zero-data write arms ch2", host_irq, 1);
        do_read(16'h3290, 8'h01, "R4 ch2 status set");
        drv_irq = 2'b00;
        idle(3);
        check(host_irq == 1'b0, "R5 host follows status level", host_irq, 0);
        do_read(16'h3290, 8'h00, "R4 ch2 status cleared");

        do_write(16'h0000, 8'hFF);
        idle(0);
        check(dma_ch2_sel == 1'b1 && xreg_en == 1'b1, "R7 route set",
              {dma_ch2_sel, xreg_en}, 3);
        do_read(16'h0000, 8'h21, "R7 route readback");
        do_write(16'h0000, 8'h20);
        idle(0);
        check(dma_ch2_sel == 1'b0 && xreg_en == 1'b1, "R7 route bit5 only",
              {dma_ch2_sel, xreg_en}, 1);
        do_write(16'h0000, 8'h00);
        idle(0);
        check(dma_ch2_sel == 1'b0 && xreg_en == 1'b0, "R7 zero clears route",
              {dma_ch2_sel, xreg_en}, 0);
        do_read(16'h0000, 8'h00, "R7 route readback cleared");

        idle(2);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule